// File: doc/BRIEF.md
# MSI Message Generator with Pending Replay

This block turns per-vector interrupt requests from a device's function logic into message-signalled interrupt writes. It takes the live contents of the capability registers as inputs: the global enable, the multiple-message-enable field, the address words, the 16-bit data word and the per-vector mask bits. From these it forms a 64-bit address and a 32-bit data word for each request and offers them one at a time on a valid/ready interface. The logic that encodes the bus write sits downstream and is not part of this block.

The block keeps the per-vector pending bits itself and exposes them so the capability block can return them on reads. A request for a masked vector sets its pending bit and sends nothing. The vector is delivered later, when its mask bit falls or when software writes the capability while the function is enabled. Requests wait in a request-bit register. They leave it lowest vector first, so any replay also comes out in ascending vector order.

Top module: `msi_msg_gen`

## Requirements
- R1: While reset is held, and right after it, `msg_valid_o`, `pending_o` and `bad_req_o` are all zero.
- R2: The enabled vector count is N = 2^min(`vec_log2_i`, log2(NUM_VEC)). `msg_data_o` is `data_i` zero-extended to 32 bits. When N > 1, its low log2(N) bits are replaced by the vector number.
- R3: With ADDR64 = 1, `msg_addr_o` is {`addr_hi_i`, `addr_lo_i`}. With ADDR64 = 0, it is {32'h0, `addr_lo_i`}. In both cases address bits [1:0] are forced to zero.
- R4: A request on `req_i[v]` with v >= N, made while enabled, raises `bad_req_o` for exactly one cycle, in the cycle after the request. It sends no message and sets no pending bit.
- R5: A request made while `msi_en_i` is low is dropped. It produces no message and sets no pending bit.
- R6: With MASK_CAP = 1, a request for vector v while `mask_i[v]` = 1 sets `pending_o[v]` and sends no message.
- R7: With MASK_CAP = 0, `mask_i` is ignored and `pending_o` stays zero.
- R8: When `mask_i[v]` falls while enabled and `pending_o[v]` is set, the pending bit clears and vector v's message is sent.
- R9: A `cfg_wr_i` pulse while enabled clears every pending bit at or above N.
- R10: In that same case, every pending vector whose mask bit is clear has its pending bit cleared and its message sent, in ascending vector order.
- R11: A presented message keeps `msg_valid_o` high, with address, data and vector unchanged, until the cycle in which `msg_ready_i` is high.
- R12: When several vectors are queued, the lowest-numbered vector is presented first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_en_i | input | 1 | Global message-interrupt enable from the capability block |
| vec_log2_i | input | 3 | Multiple-message-enable field (log2 of the vector count) |
| addr_lo_i | input | 32 | Low address word |
| addr_hi_i | input | 32 | High address word (used only with ADDR64 = 1) |
| data_i | input | 16 | Message data word |
| mask_i | input | NUM_VEC | Per-vector mask bits |
| cfg_wr_i | input | 1 | One-cycle pulse for a software write to the capability |
| req_i | input | NUM_VEC | Per-vector request pulses |
| msg_ready_i | input | 1 | Downstream accepts the presented message |
| msg_valid_o | output | 1 | A message is presented |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 32 | Message data |
| msg_vec_o | output | log2(NUM_VEC) | Vector number of the presented message |
| pending_o | output | NUM_VEC | Pending bits |
| bad_req_o | output | 1 | One-cycle flag for a request at or above the enabled count |

## Verification
The bench builds two copies with eight vectors. The first has 64-bit addressing and masking. The second has 32-bit addressing and no masking, and it shares the same stimulus. With eight vectors, a sweep of every multiple-message-enable value (including one above the maximum, which must clamp) against every vector stays short. That sweep covers each in-range data substitution and each out-of-range flag. The masked copy exercises mask-then-unmask, discarding by a config write after the count shrinks, and replay by a config write after an unmask made while disabled. The copy without masking shows that the mask inputs have no effect and that the upper address half is cleared.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;
   localparam int LOG_FIELD_W  = 3;
   localparam int DATA_IN_W    = 16;
   localparam int MSG_DATA_W   = 32;
   localparam int MSG_ADDR_W   = 64;
   localparam int VEC_LIMIT    = 32;

   function automatic int vec_idx_w(input int nvec);
      return (nvec > 1) ? $clog2(nvec) : 1;
   endfunction
endpackage

// File: rtl/msi_vec_cfg.sv
module msi_vec_cfg
   import msi_gen_pkg::*;
#(
   parameter int NUM_VEC  = 8,
   parameter bit MASK_CAP = 1'b1
) (
   input  logic [LOG_FIELD_W-1:0] vec_log2_i,
   input  logic [NUM_VEC-1:0]     mask_i,
   output logic [LOG_FIELD_W-1:0] eff_log2_o,
   output logic [NUM_VEC-1:0]     in_range_o,
   output logic [NUM_VEC-1:0]     mask_eff_o
);
   localparam int MAX_LOG2 = $clog2(NUM_VEC);

   // clamp a count request above the implemented maximum
   assign eff_log2_o = (vec_log2_i > LOG_FIELD_W'(MAX_LOG2)) ?
                       LOG_FIELD_W'(MAX_LOG2) : vec_log2_i;

   for (genvar i = 0; i < NUM_VEC; i++) begin : g_range
      assign in_range_o[i] = ((32'(i) >> eff_log2_o) == 32'd0);
   end

   if (MASK_CAP) begin : g_mask
      assign mask_eff_o = mask_i;
   end else begin : g_nomask
      assign mask_eff_o = '0;
   end
endmodule

// File: rtl/msi_pend_track.sv
module msi_pend_track #(
   parameter int NUM_VEC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic [NUM_VEC-1:0] req_i,
   input  logic [NUM_VEC-1:0] in_range_i,
   input  logic [NUM_VEC-1:0] mask_i,
   input  logic               cfg_wr_i,
   input  logic [NUM_VEC-1:0] take_i,
   output logic [NUM_VEC-1:0] queue_o,
   output logic [NUM_VEC-1:0] pending_o,
   output logic               bad_o
);
   logic [NUM_VEC-1:0] live, good, to_pend, to_queue;
   logic [NUM_VEC-1:0] mask_q, fell, pend_kept, replay;
   logic [NUM_VEC-1:0] pend_n, queue_n;
   logic               cfg_hit, bad_n;

   always_comb begin
      live      = en_i ? req_i : '0;
      good      = live & in_range_i;
      bad_n     = |(live & ~in_range_i);
      to_pend   = good & mask_i;
      to_queue  = good & ~mask_i;
      fell      = mask_q & ~mask_i;
      cfg_hit   = cfg_wr_i & en_i;
      pend_kept = cfg_hit ? (pending_o & in_range_i) : pending_o;
      replay    = en_i ? (pend_kept & ~mask_i & (cfg_hit ? '1 : fell)) : '0;
      pend_n    = (pend_kept & ~replay) | to_pend;
      queue_n   = (queue_o & ~take_i) | to_queue | replay;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         pending_o <= '0;
         queue_o   <= '0;
         bad_o     <= 1'b0;
      end else begin
         mask_q    <= mask_i;
         pending_o <= pend_n;
         queue_o   <= queue_n;
         bad_o     <= bad_n;
      end
   end
endmodule

// File: rtl/msi_msg_build.sv
module msi_msg_build
   import msi_gen_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter bit ADDR64  = 1'b1,
   parameter int VW      = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_VEC-1:0]     queue_i,
   input  logic [LOG_FIELD_W-1:0] eff_log2_i,
   input  logic [31:0]            addr_lo_i,
   input  logic [31:0]            addr_hi_i,
   input  logic [DATA_IN_W-1:0]   data_i,
   input  logic                   ready_i,
   output logic [NUM_VEC-1:0]     take_o,
   output logic                   valid_o,
   output logic [MSG_ADDR_W-1:0]  addr_o,
   output logic [MSG_DATA_W-1:0]  data_o,
   output logic [VW-1:0]          vec_o
);
   logic [VW-1:0]         sel;
   logic                  load;
   logic [DATA_IN_W-1:0]  low_mask, data_v;
   logic [MSG_ADDR_W-1:0] addr_v;
   logic [31:0]           lo_aligned;

   always_comb begin
      sel = '0;
      for (int i = NUM_VEC - 1; i >= 0; i--) begin
         if (queue_i[i]) sel = VW'(i);
      end
   end

   assign load   = (|queue_i) && (!valid_o || ready_i);
   assign take_o = load ? (NUM_VEC'(1) << sel) : '0;

   assign low_mask = DATA_IN_W'((17'd1 << eff_log2_i) - 17'd1);
   assign data_v   = (data_i & ~low_mask) |
                     ({{(DATA_IN_W-VW){1'b0}}, sel} & low_mask);
   assign lo_aligned = addr_lo_i & ~32'h3;

   if (ADDR64) begin : g_a64
      assign addr_v = {addr_hi_i, lo_aligned};
   end else begin : g_a32
      assign addr_v = {32'h0, lo_aligned};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         addr_o  <= '0;
         data_o  <= '0;
         vec_o   <= '0;
      end else if (load) begin
         valid_o <= 1'b1;
         addr_o  <= addr_v;
         data_o  <= {{(MSG_DATA_W-DATA_IN_W){1'b0}}, data_v};
         vec_o   <= sel;
      end else if (ready_i) begin
         valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
   import msi_gen_pkg::*;
#(
   parameter int NUM_VEC  = 8,
   parameter bit ADDR64   = 1'b1,
   parameter bit MASK_CAP = 1'b1,
   localparam int VW      = vec_idx_w(NUM_VEC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   msi_en_i,
   input  logic [LOG_FIELD_W-1:0] vec_log2_i,
   input  logic [31:0]            addr_lo_i,
   input  logic [31:0]            addr_hi_i,
   input  logic [DATA_IN_W-1:0]   data_i,
   input  logic [NUM_VEC-1:0]     mask_i,
   input  logic                   cfg_wr_i,
   input  logic [NUM_VEC-1:0]     req_i,
   input  logic                   msg_ready_i,
   output logic                   msg_valid_o,
   output logic [MSG_ADDR_W-1:0]  msg_addr_o,
   output logic [MSG_DATA_W-1:0]  msg_data_o,
   output logic [VW-1:0]          msg_vec_o,
   output logic [NUM_VEC-1:0]     pending_o,
   output logic                   bad_req_o
);
   if (NUM_VEC < 1 || NUM_VEC > VEC_LIMIT || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_cfg
      $error("msi_msg_gen: NUM_VEC must be a power of two from 1 to 32");
   end

   logic [LOG_FIELD_W-1:0] eff_log2;
   logic [NUM_VEC-1:0]     in_range, mask_eff, queue, take;

   msi_vec_cfg #(.NUM_VEC(NUM_VEC), .MASK_CAP(MASK_CAP)) u_cfg (
      .vec_log2_i (vec_log2_i),
      .mask_i     (mask_i),
      .eff_log2_o (eff_log2),
      .in_range_o (in_range),
      .mask_eff_o (mask_eff)
   );

   msi_pend_track #(.NUM_VEC(NUM_VEC)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (msi_en_i),
      .req_i      (req_i),
      .in_range_i (in_range),
      .mask_i     (mask_eff),
      .cfg_wr_i   (cfg_wr_i),
      .take_i     (take),
      .queue_o    (queue),
      .pending_o  (pending_o),
      .bad_o      (bad_req_o)
   );

   msi_msg_build #(.NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .VW(VW)) u_build (
      .clk        (clk),
      .rst_n      (rst_n),
      .queue_i    (queue),
      .eff_log2_i (eff_log2),
      .addr_lo_i  (addr_lo_i),
      .addr_hi_i  (addr_hi_i),
      .data_i     (data_i),
      .ready_i    (msg_ready_i),
      .take_o     (take),
      .valid_o    (msg_valid_o),
      .addr_o     (msg_addr_o),
      .data_o     (msg_data_o),
      .vec_o      (msg_vec_o)
   );
endmodule

// File: rtl/msi_msg_gen_chk.sv
module msi_msg_gen_chk #(
   parameter int NUM_VEC  = 8,
   parameter bit ADDR64   = 1'b1,
   parameter bit MASK_CAP = 1'b1,
   parameter int VW       = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               msi_en_i,
   input logic [NUM_VEC-1:0] pending_o,
   input logic               msg_valid_o,
   input logic               msg_ready_i,
   input logic [63:0]        msg_addr_o,
   input logic [31:0]        msg_data_o,
   input logic [VW-1:0]      msg_vec_o,
   input logic               bad_req_o
);
   assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_addr_o) &&
                                         $stable(msg_data_o) && $stable(msg_vec_o)));

   assert_data_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid_o |-> (msg_data_o[31:16] == 16'h0));

   assert_addr_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid_o |-> ((msg_addr_o[1:0] == 2'b00) &&
                       (ADDR64 || (msg_addr_o[63:32] == 32'h0))));

   assert_no_pend_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !msi_en_i |=> ((pending_o & ~$past(pending_o)) == '0));

   assert_bad_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bad_req_o) |-> $past(msi_en_i));

   if (!MASK_CAP) begin : g_nomask_chk
      assert_no_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
         msg_valid_o || !msg_valid_o |-> (pending_o == '0));
   end
endmodule

bind msi_msg_gen msi_msg_gen_chk #(
   .NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .MASK_CAP(MASK_CAP), .VW(VW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .msi_en_i    (msi_en_i),
   .pending_o   (pending_o),
   .msg_valid_o (msg_valid_o),
   .msg_ready_i (msg_ready_i),
   .msg_addr_o  (msg_addr_o),
   .msg_data_o  (msg_data_o),
   .msg_vec_o   (msg_vec_o),
   .bad_req_o   (bad_req_o)
);

// File: tb/msi_msg_gen_bench.sv
module msi_msg_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [2:0]  log2f = 3'd0;
   logic [31:0] lo = 32'h0, hi = 32'h0;
   logic [15:0] dat = 16'h0;
   logic [NV-1:0] mask = '0, req = '0;
   logic        cfg_wr = 1'b0, ready = 1'b1;

   logic        valid, bad;
   logic [63:0] addr;
   logic [31:0] data;
   logic [2:0]  vec;
   logic [NV-1:0] pend;

   logic        valid_b, bad_b;
   logic [63:0] addr_b;
   logic [31:0] data_b;
   logic [2:0]  vec_b;
   logic [NV-1:0] pend_b;

   int nchk = 0, nfail = 0;
   int nlog = 0, nbad = 0, nlog_b = 0;
   logic [2:0]  lv [0:255];
   logic [31:0] ld [0:255];
   logic [63:0] la [0:255];
   logic [63:0] last_addr_b;

   always #(CLK_PERIOD/2) clk = ~clk;

   msi_msg_gen #(.NUM_VEC(NV), .ADDR64(1'b1), .MASK_CAP(1'b1)) u_msi_msg_gen (
      .clk(clk), .rst_n(rst_n), .msi_en_i(en), .vec_log2_i(log2f),
      .addr_lo_i(lo), .addr_hi_i(hi), .data_i(dat), .mask_i(mask),
      .cfg_wr_i(cfg_wr), .req_i(req), .msg_ready_i(ready),
      .msg_valid_o(valid), .msg_addr_o(addr), .msg_data_o(data),
      .msg_vec_o(vec), .pending_o(pend), .bad_req_o(bad));

   msi_msg_gen #(.NUM_VEC(NV), .ADDR64(1'b0), .MASK_CAP(1'b0)) u_msi_msg_gen_lite (
      .clk(clk), .rst_n(rst_n), .msi_en_i(en), .vec_log2_i(log2f),
      .addr_lo_i(lo), .addr_hi_i(hi), .data_i(dat), .mask_i(mask),
      .cfg_wr_i(cfg_wr), .req_i(req), .msg_ready_i(1'b1),
      .msg_valid_o(valid_b), .msg_addr_o(addr_b), .msg_data_o(data_b),
      .msg_vec_o(vec_b), .pending_o(pend_b), .bad_req_o(bad_b));

   // monitors sample at the falling edge; a handshake completes on the next rise
   always @(negedge clk) begin
      if (rst_n && valid && ready) begin
         lv[nlog[7:0]] <= vec; ld[nlog[7:0]] <= data; la[nlog[7:0]] <= addr;
         nlog <= nlog + 1;
      end
      if (rst_n && bad) nbad <= nbad + 1;
      if (rst_n && valid_b) begin
         nlog_b <= nlog_b + 1;
         last_addr_b <= addr_b;
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_req(input logic [NV-1:0] r);
      @(negedge clk); req = r;
      @(negedge clk); req = '0;
   endtask

   task automatic pulse_cfg();
      @(negedge clk); cfg_wr = 1'b1;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   function automatic logic [31:0] exp_data(input logic [15:0] d, input int l, input int v);
      logic [15:0] m;
      m = 16'((1 << l) - 1);
      return {16'h0, (d & ~m) | (16'(v) & m)};
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", nchk, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin : stim
      int base, bbase, eff;
      logic [31:0] hold_d;
      cyc(2);
      // R1: reset state
      chk(valid == 1'b0, "R1 valid", 64'(valid), 0);
      chk(pend == '0, "R1 pending", 64'(pend), 0);
      chk(bad == 1'b0, "R1 bad", 64'(bad), 0);
      rst_n = 1'b1;
      cyc(1);
      chk(valid == 1'b0 && pend == '0, "R1 after release", 64'(pend), 0);

      // R2/R3/R4 sweep: every count field against every vector
      en = 1'b1; lo = 32'hFEE0_1003; hi = 32'h0000_00AB; dat = 16'hA5F7; mask = '0;
      for (int li = 0; li < 5; li++) begin
         int lf;
         lf = (li == 4) ? 5 : li;
         log2f = 3'(lf);
         eff = (lf > 3) ? 3 : lf;
         for (int v = 0; v < NV; v++) begin
            base = nlog; bbase = nbad;
            pulse_req(NV'(1) << v);
            cyc(4);
            if (v < (1 << eff)) begin
               chk(nlog == base + 1, "R2 message count", 64'(nlog - base), 1);
               chk(lv[base[7:0]] == 3'(v), "R2 vector", 64'(lv[base[7:0]]), 64'(v));
               chk(ld[base[7:0]] == exp_data(dat, eff, v), "R2 data",
                   64'(ld[base[7:0]]), 64'(exp_data(dat, eff, v)));
               chk(la[base[7:0]] == 64'h0000_00AB_FEE0_1000, "R3 address 64",
                   la[base[7:0]], 64'h0000_00AB_FEE0_1000);
               chk(nbad == bbase, "R4 no flag in range", 64'(nbad - bbase), 0);
            end else begin
               chk(nbad == bbase + 1, "R4 flag count", 64'(nbad - bbase), 1);
               chk(nlog == base, "R4 dropped", 64'(nlog - base), 0);
               chk(pend == '0, "R4 no pending", 64'(pend), 0);
            end
         end
      end

      // R3/R7: 32-bit copy without masking
      chk(last_addr_b == 64'h0000_0000_FEE0_1000, "R3 address 32", last_addr_b, 64'hFEE0_1000);

      // R5: requests while disabled
      en = 1'b0; log2f = 3'd3;
      base = nlog; bbase = nbad;
      pulse_req('1);
      cyc(4);
      chk(nlog == base, "R5 no message", 64'(nlog - base), 0);
      chk(pend == '0, "R5 no pending", 64'(pend), 0);
      chk(nbad == bbase, "R5 no flag", 64'(nbad - bbase), 0);

      // R6: masked requests become pending; R7 on the lite copy
      en = 1'b1; mask = 8'h24;
      cyc(1);
      base = nlog; bbase = nlog_b;
      pulse_req(8'h24);
      cyc(4);
      chk(pend == 8'h24, "R6 pending set", 64'(pend), 64'h24);
      chk(nlog == base, "R6 no message", 64'(nlog - base), 0);
      chk(nlog_b == bbase + 2, "R7 mask ignored", 64'(nlog_b - bbase), 2);
      chk(pend_b == '0, "R7 no pending", 64'(pend_b), 0);

      // R8: unmask vector 5
      base = nlog;
      @(negedge clk); mask = 8'h04;
      cyc(4);
      chk(nlog == base + 1 && lv[base[7:0]] == 3'd5, "R8 replay vector 5",
          64'(lv[base[7:0]]), 5);
      chk(pend == 8'h04, "R8 pending cleared", 64'(pend), 64'h04);

      // R9: shrink the count, config write discards high pending bits
      mask = 8'h46;
      cyc(1);
      pulse_req(8'h42);
      cyc(3);
      chk(pend == 8'h46, "R6 pending accumulate", 64'(pend), 64'h46);
      base = nlog;
      log2f = 3'd2;
      pulse_cfg();
      cyc(3);
      chk(pend == 8'h06, "R9 discard above count", 64'(pend), 64'h06);
      chk(nlog == base, "R9 masked not sent", 64'(nlog - base), 0);

      // unmask while disabled: nothing replays yet
      @(negedge clk); en = 1'b0; mask = '0;
      cyc(3);
      chk(pend == 8'h06, "R8 no replay while disabled", 64'(pend), 64'h06);

      // R10: config write while enabled replays ascending
      @(negedge clk); en = 1'b1; cfg_wr = 1'b1;
      @(negedge clk); cfg_wr = 1'b0;
      cyc(5);
      chk(nlog == base + 2, "R10 replay count", 64'(nlog - base), 2);
      chk(lv[base[7:0]] == 3'd1 && lv[(base+1) & 255] == 3'd2, "R10 ascending order",
          64'({lv[base[7:0]], lv[(base+1) & 255]}), 64'h0A);
      chk(ld[base[7:0]] == exp_data(dat, 2, 1), "R10 data", 64'(ld[base[7:0]]),
          64'(exp_data(dat, 2, 1)));
      chk(pend == '0, "R10 pending cleared", 64'(pend), 0);

      // R11/R12: backpressure with three simultaneous requests
      log2f = 3'd3; ready = 1'b0;
      base = nlog;
      pulse_req(8'h0B);
      cyc(2);
      chk(valid == 1'b1 && vec == 3'd0, "R12 lowest first", 64'(vec), 0);
      hold_d = data;
      dat = 16'h1234;
      cyc(5);
      chk(valid == 1'b1 && vec == 3'd0, "R11 held valid", 64'(vec), 0);
      chk(data == hold_d, "R11 held data", 64'(data), 64'(hold_d));
      dat = 16'hA5F7;
      @(negedge clk); ready = 1'b1;
      cyc(6);
      chk(nlog == base + 3, "R12 count", 64'(nlog - base), 3);
      chk(lv[base[7:0]] == 3'd0 && lv[(base+1) & 255] == 3'd1 && lv[(base+2) & 255] == 3'd3,
          "R12 order", 64'({lv[base[7:0]], lv[(base+1) & 255], lv[(base+2) & 255]}), 64'o013);
      chk(ld[(base+2) & 255] == exp_data(16'hA5F7, 3, 3), "R2 data after hold",
          64'(ld[(base+2) & 255]), 64'(exp_data(16'hA5F7, 3, 3)));

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule